// File: doc/BRIEF.md
# Dual-Sensor Thermal Governor

This block polls two serial digital temperature sensors at once. The sensors share one serial clock and one active-low select line, and each sensor has its own data line. The poll repeats without a gap. After each poll the block turns every 16-bit sensor code into a signed temperature in 1/32 °C steps and sets a temperature output for each channel.

Each channel also has a clock multiplier and a "cool maximum" cap, and these are passed to an external clock synthesizer. The operating frequency in MHz is twice the multiplier. When a channel runs hotter than its target plus a hysteresis band, the multiplier drops by one step. A one-second tick limits this to one drop per second. When the channel is cooler than the target, the cap is released again. If the temperature is below the band, the cap returns to the absolute maximum at once. If the temperature is inside the band, the cap rises by one step at a time. Codes of all zeros or all ones mean the sensor is missing or has failed. Such a code is reported as zero degrees and leaves the governor alone.

Top module: `thermal_governor`

## Requirements
- R1: Each poll follows this order. Two clock pulses are sent with select high. Select then goes low for 16 clock pulses, and both data lines are sampled late in each high phase, most significant bit first. Select goes high again, and two more pulses follow. The select line changes only while the clock is low. Each clock phase lasts HALF_CYC cycles, and the next poll starts at once.
- R2: After a poll ends, each channel's temperature output becomes its code arithmetically shifted right by two. The result is a signed 14-bit value in units of 1/32 °C.
- R3: Code 0x0000 and code 0xFFFF are invalid. An invalid code sets that channel's temperature output to 0 and leaves its multiplier and cap unchanged.
- R4: A valid reading whose rounded temperature is above target plus hysteresis lowers the multiplier by one and sets the cap equal to the new multiplier. This happens once after reset and then at most once for each tick_1s pulse. If a drop and a tick fall in the same cycle, the tick is used up by that drop.
- R5: The multiplier never goes below 1. A hot reading at a multiplier of 1 keeps the multiplier at 1 and sets the cap to 1.
- R6: If a reading is not hot, the cap is below abs_max_mult and the rounded temperature is below target minus hysteresis, the cap becomes abs_max_mult.
- R7: If a reading is not hot, the cap is below abs_max_mult, the rounded temperature is at least target minus hysteresis but below target, and the multiplier equals the cap, the cap rises by one.
- R8: The rounded temperature is the nearest whole degree, with halves rounded upward. It is compared as a signed value, and exactly target plus hysteresis does not count as hot.
- R9: Reset sets the multiplier and the cap to DEF_MULT (default 100) and the temperatures to 0. It also holds select high and the clock low.
- R10: clk_mhz always equals twice the channel's multiplier.
- R11: The two channels are governed independently. A reading on one channel never changes the other channel's multiplier, cap or temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sens_dat | input | 2 | Serial data from sensor 0 (bit 0) and sensor 1 (bit 1) |
| tick_1s | input | 1 | One-cycle pulse once per second; re-arms throttling |
| target_deg | input | 10 | Signed target temperature in whole °C |
| hyst_deg | input | 9 | Unsigned hysteresis in whole °C |
| abs_max_mult | input | 8 | Absolute maximum multiplier |
| sens_clk | output | 1 | Shared sensor serial clock |
| sens_cs_n | output | 1 | Shared sensor select, active low |
| temp_q5 | output | 2x14 | Signed temperature per channel, 1/32 °C |
| mult | output | 2x8 | Current clock multiplier per channel |
| cap | output | 2x8 | Cool-maximum multiplier cap per channel |
| clk_mhz | output | 2x9 | Operating frequency per channel in MHz |

## Verification
The checks take abs_max_mult as fixed and no smaller than DEF_MULT. They take the sensors as answering within the window in which the block drives select low. The cap bound and the single-step fall of the multiplier both rest on these facts. The testbench holds target, hysteresis and the maximum constant for the whole run. Its sensor model shifts a new bit out on each rising clock edge while selected, and the block samples that bit late in the high phase. Ticks are pulsed only between polls that the bench controls, so every drop of the multiplier can be traced to a known tick.

// File: rtl/thermgov_pkg.sv
package thermgov_pkg;

    localparam int NCH          = 2;
    localparam int CODE_W       = 16;
    localparam int FRAC_DROP    = 2;
    localparam int Q_W          = CODE_W - FRAC_DROP;
    localparam int DEG_SH       = 5;
    localparam int DEG_W        = Q_W + 1 - DEG_SH;
    localparam int LEAD_PULSES  = 2;
    localparam int TAIL_PULSES  = 2;
    localparam int FRAME_PULSES = LEAD_PULSES + CODE_W + TAIL_PULSES;

    localparam logic [Q_W:0] ROUND_BIAS = (Q_W + 1)'(1 << (DEG_SH - 1));

    typedef enum logic [1:0] {
        PH_LEAD,
        PH_DATA,
        PH_TAIL
    } frame_ph_e;

    typedef struct packed {
        logic                    ok;
        logic signed [Q_W-1:0]   q5;
        logic signed [DEG_W-1:0] deg;
    } reading_t;

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return (c != '0) && (c != '1);
    endfunction

    // arithmetic shift right, truncated to the surviving bits
    function automatic logic signed [Q_W-1:0] code_to_q(input logic [CODE_W-1:0] c);
        return $signed(c[CODE_W-1:FRAC_DROP]);
    endfunction

    // nearest whole degree, halves upward
    function automatic logic signed [DEG_W-1:0] q_to_deg(input logic signed [Q_W-1:0] q);
        logic [Q_W:0] sum;
        sum = {q[Q_W-1], q} + ROUND_BIAS;
        return $signed(sum[Q_W:DEG_SH]);
    endfunction

endpackage

// File: rtl/tsense_serial_rx.sv
module tsense_serial_rx
    import thermgov_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCH-1:0]               sdat,
    output logic                         sclk,
    output logic                         scs_n,
    output logic                         frame_done,
    output logic [NCH-1:0][CODE_W-1:0]   codes
);

    localparam int IDX_W = $clog2(FRAME_PULSES);
    localparam int HC_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [IDX_W-1:0] idx;
    logic [HC_W-1:0]  hcnt;
    logic             hi;
    logic             end_half;
    frame_ph_e        ph;

    assign end_half = (hcnt == HC_W'(HALF_CYC - 1));

    always_comb begin
        if (idx < IDX_W'(LEAD_PULSES))
            ph = PH_LEAD;
        else if (idx < IDX_W'(LEAD_PULSES + CODE_W))
            ph = PH_DATA;
        else
            ph = PH_TAIL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx        <= '0;
            hcnt       <= '0;
            hi         <= 1'b0;
            frame_done <= 1'b0;
            codes      <= '0;
        end else begin
            frame_done <= 1'b0;
            if (end_half) begin
                hcnt <= '0;
                hi   <= ~hi;
                if (hi) begin
                    if (ph == PH_DATA) begin
                        for (int c = 0; c < NCH; c++)
                            codes[c] <= {codes[c][CODE_W-2:0], sdat[c]};
                    end
                    if (idx == IDX_W'(FRAME_PULSES - 1)) begin
                        idx        <= '0;
                        frame_done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign sclk  = hi;
    assign scs_n = (ph != PH_DATA);

endmodule

// File: rtl/tcode_decode.sv
module tcode_decode
    import thermgov_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output reading_t          rd
);

    logic signed [Q_W-1:0] q;

    always_comb begin
        q      = code_to_q(code);
        rd.ok  = code_ok(code);
        rd.q5  = rd.ok ? q : '0;
        rd.deg = rd.ok ? q_to_deg(q) : '0;
    end

endmodule

// File: rtl/mult_governor.sv
module mult_governor
    import thermgov_pkg::*;
#(
    parameter int MULT_W   = 8,
    parameter int DEF_MULT = 100
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic                    tick,
    input  reading_t                smp,
    input  logic signed [DEG_W-1:0] target,
    input  logic [DEG_W-2:0]        hyst,
    input  logic [MULT_W-1:0]       abs_max,
    output logic [MULT_W-1:0]       mult,
    output logic [MULT_W-1:0]       cap
);

    localparam int CMP_W = DEG_W + 2;

    logic signed [CMP_W-1:0] deg_x, tgt_x, hys_x, hot_th, cold_th;
    logic [MULT_W-1:0]       nxt;
    logic                    cut_ok;

    always_comb begin
        deg_x   = {{2{smp.deg[DEG_W-1]}}, smp.deg};
        tgt_x   = {{2{target[DEG_W-1]}}, target};
        hys_x   = {3'b000, hyst};
        hot_th  = tgt_x + hys_x;
        cold_th = tgt_x - hys_x;
        nxt     = (mult > MULT_W'(1)) ? mult - 1'b1 : MULT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mult   <= MULT_W'(DEF_MULT);
            cap    <= MULT_W'(DEF_MULT);
            cut_ok <= 1'b1;
        end else begin
            if (tick)
                cut_ok <= 1'b1;
            if (upd && smp.ok) begin
                if (deg_x > hot_th) begin
                    if (cut_ok) begin
                        mult   <= nxt;
                        cap    <= nxt;
                        cut_ok <= 1'b0;
                    end
                end else if ((cap < abs_max) && (deg_x < tgt_x)) begin
                    if (deg_x < cold_th)
                        cap <= abs_max;
                    else if (mult == cap)
                        cap <= cap + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/thermal_governor.sv
module thermal_governor
    import thermgov_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int MULT_W   = 8,
    parameter int DEF_MULT = 100
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCH-1:0]               sens_dat,
    input  logic                         tick_1s,
    input  logic signed [DEG_W-1:0]      target_deg,
    input  logic [DEG_W-2:0]             hyst_deg,
    input  logic [MULT_W-1:0]            abs_max_mult,
    output logic                         sens_clk,
    output logic                         sens_cs_n,
    output logic [NCH-1:0][Q_W-1:0]      temp_q5,
    output logic [NCH-1:0][MULT_W-1:0]   mult,
    output logic [NCH-1:0][MULT_W-1:0]   cap,
    output logic [NCH-1:0][MULT_W:0]     clk_mhz
);

    logic                       frame_done;
    logic [NCH-1:0][CODE_W-1:0] codes;

    tsense_serial_rx #(.HALF_CYC(HALF_CYC)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .sdat       (sens_dat),
        .sclk       (sens_clk),
        .scs_n      (sens_cs_n),
        .frame_done (frame_done),
        .codes      (codes)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        reading_t rdg;

        tcode_decode u_dec (
            .code (codes[g]),
            .rd   (rdg)
        );

        always_ff @(posedge clk) begin
            if (rst)
                temp_q5[g] <= '0;
            else if (frame_done)
                temp_q5[g] <= rdg.q5;
        end

        mult_governor #(.MULT_W(MULT_W), .DEF_MULT(DEF_MULT)) u_gov (
            .clk     (clk),
            .rst     (rst),
            .upd     (frame_done),
            .tick    (tick_1s),
            .smp     (rdg),
            .target  (target_deg),
            .hyst    (hyst_deg),
            .abs_max (abs_max_mult),
            .mult    (mult[g]),
            .cap     (cap[g])
        );

        assign clk_mhz[g] = {mult[g], 1'b0};
    end

endmodule

// File: rtl/thermgov_chk.sv
module thermgov_chk
    import thermgov_pkg::*;
#(
    parameter int MULT_W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tick_1s,
    input logic                       sens_clk,
    input logic                       sens_cs_n,
    input logic [MULT_W-1:0]          abs_max_mult,
    input logic [NCH-1:0][MULT_W-1:0] mult,
    input logic [NCH-1:0][MULT_W-1:0] cap
);

    logic tick_d;

    always_ff @(posedge clk) tick_d <= tick_1s;

    // R1
    sel_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sens_cs_n) |-> !sens_clk);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic [MULT_W-1:0] mult_d;
        logic              gap, first, drop;

        assign drop = mult[g] < mult_d;

        always_ff @(posedge clk) begin
            mult_d <= mult[g];
            if (rst) begin
                first <= 1'b1;
                gap   <= 1'b0;
            end else if (drop) begin
                first <= 1'b0;
                gap   <= 1'b0;
            end else if (tick_d) begin
                gap <= 1'b1;
            end
        end

        // R5
        mult_floor_chk: assert property (@(posedge clk) disable iff (rst)
            mult[g] != '0);

        // R4
        mult_le_cap_chk: assert property (@(posedge clk) disable iff (rst)
            mult[g] <= cap[g]);

        // R4
        mult_step_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(mult[g]) |-> (mult[g] == $past(mult[g]) - 1'b1));

        // R4
        cut_rate_chk: assert property (@(posedge clk) disable iff (rst)
            drop |-> (first || gap));

        // R6
        cap_le_max_chk: assert property (@(posedge clk) disable iff (rst)
            cap[g] <= abs_max_mult);
    end

endmodule

bind thermal_governor thermgov_chk #(.MULT_W(MULT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_1s      (tick_1s),
    .sens_clk     (sens_clk),
    .sens_cs_n    (sens_cs_n),
    .abs_max_mult (abs_max_mult),
    .mult         (mult),
    .cap          (cap)
);

// File: tb/test_thermal_governor.sv
module test_thermal_governor;
    import thermgov_pkg::*;

    localparam int CLK_PER = 10;
    localparam int MW      = 8;

    typedef struct packed {
        logic              tk;
        logic [15:0]       c0;
        logic [15:0]       c1;
        logic signed [15:0] t0;
        logic signed [15:0] t1;
        logic [7:0]        m0;
        logic [7:0]        m1;
        logic [7:0]        p0;
        logic [7:0]        p1;
    } vec_t;

    // target 60, hysteresis 5, maximum 125
    localparam vec_t TBL [8] = '{
        '{1'b0, 16'h2300, 16'h1900,  16'sd2240, 16'sd1600, 8'd99, 8'd100, 8'd99,  8'd125},
        '{1'b0, 16'h2300, 16'h1900,  16'sd2240, 16'sd1600, 8'd99, 8'd100, 8'd99,  8'd125},
        '{1'b1, 16'h2300, 16'h1900,  16'sd2240, 16'sd1600, 8'd98, 8'd100, 8'd98,  8'd125},
        '{1'b0, 16'h1D00, 16'h0000,  16'sd1856, 16'sd0,    8'd98, 8'd100, 8'd99,  8'd125},
        '{1'b0, 16'hFFFF, 16'h2100,  16'sd0,    16'sd2112, 8'd98, 8'd99,  8'd99,  8'd99},
        '{1'b0, 16'h1400, 16'h2080,  16'sd1280, 16'sd2080, 8'd98, 8'd99,  8'd125, 8'd99},
        '{1'b0, 16'hFB00, 16'h20C3, -16'sd320,  16'sd2096, 8'd98, 8'd99,  8'd125, 8'd99},
        '{1'b1, 16'hFB00, 16'h20C3, -16'sd320,  16'sd2096, 8'd98, 8'd98,  8'd125, 8'd98}
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     tick = 1'b0;
    logic [NCH-1:0]           sens_dat;
    logic signed [DEG_W-1:0]  target = 10'sd60;
    logic [DEG_W-2:0]         hyst = 9'd5;
    logic [MW-1:0]            abs_max = 8'd125;
    logic                     sens_clk, sens_cs_n;
    logic [NCH-1:0][Q_W-1:0]  temp_q5;
    logic [NCH-1:0][MW-1:0]   mult, cap;
    logic [NCH-1:0][MW:0]     clk_mhz;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    thermal_governor i_thermal_governor (
        .clk          (clk),
        .rst          (rst),
        .sens_dat     (sens_dat),
        .tick_1s      (tick),
        .target_deg   (target),
        .hyst_deg     (hyst),
        .abs_max_mult (abs_max),
        .sens_clk     (sens_clk),
        .sens_cs_n    (sens_cs_n),
        .temp_q5      (temp_q5),
        .mult         (mult),
        .cap          (cap),
        .clk_mhz      (clk_mhz)
    );

    // sensor model: word latched at select fall, next bit after each rise
    logic [15:0] word0 = 16'h0000, word1 = 16'h0000;
    logic [15:0] lat0 = 16'h0000, lat1 = 16'h0000;
    int          nrise = 0;
    int          bidx;

    always @(negedge sens_cs_n) begin
        lat0  = word0;
        lat1  = word1;
        nrise = 0;
    end

    always @(posedge sens_clk) if (!sens_cs_n) nrise = nrise + 1;

    always_comb begin
        bidx = (nrise == 0) ? 15 : ((nrise > 16) ? 0 : 16 - nrise);
        sens_dat = {lat1[bidx], lat0[bidx]};
    end

    // framing monitor (R1)
    int lo_cnt = 0, hi_cnt = 0, frames = 0, frame_err = 0, bad_lo = 0, bad_hi = 0;

    always @(posedge sens_clk) begin
        if (!sens_cs_n) lo_cnt = lo_cnt + 1;
        else            hi_cnt = hi_cnt + 1;
    end

    always @(negedge sens_cs_n) begin
        if (frames > 0 && (lo_cnt != 16 || hi_cnt != 4)) begin
            frame_err = frame_err + 1;
            bad_lo    = lo_cnt;
            bad_hi    = hi_cnt;
        end
        frames = frames + 1;
        lo_cnt = 0;
        hi_cnt = 0;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic tk, input logic [15:0] a, input logic [15:0] b);
        word0 = a;
        word1 = b;
        if (tk) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        @(negedge sens_cs_n);
        @(negedge sens_cs_n);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 mult0", mult[0], 100);
        chk("R9 cap1", cap[1], 100);
        chk("R9 temp0", int'($signed(temp_q5[0])), 0);
        chk("R9 select", sens_cs_n, 1);
        chk("R9 sclk", sens_clk, 0);
        chk("R10 mhz reset", clk_mhz[0], 200);
        rst = 1'b0;

        // R2 R3 R4 R6 R7 R8 R10 R11 table walk
        foreach (TBL[i]) begin
            apply(TBL[i].tk, TBL[i].c0, TBL[i].c1);
            chk($sformatf("R2/R3/R8 temp0 v%0d", i), int'($signed(temp_q5[0])), int'(TBL[i].t0));
            chk($sformatf("R2/R3/R8 temp1 v%0d", i), int'($signed(temp_q5[1])), int'(TBL[i].t1));
            chk($sformatf("R4/R11 mult0 v%0d", i), mult[0], TBL[i].m0);
            chk($sformatf("R4/R11 mult1 v%0d", i), mult[1], TBL[i].m1);
            chk($sformatf("R6/R7 cap0 v%0d", i), cap[0], TBL[i].p0);
            chk($sformatf("R6/R7 cap1 v%0d", i), cap[1], TBL[i].p1);
            chk($sformatf("R10 mhz0 v%0d", i), clk_mhz[0], 2 * TBL[i].m0);
        end

        // R5 floor: keep both channels hot across many ticks
        for (int k = 0; k < 120; k++) apply(1'b1, 16'h2300, 16'h20C3);
        chk("R5 mult0 floor", mult[0], 1);
        chk("R5 cap0 floor", cap[0], 1);
        chk("R5 mult1 floor", mult[1], 1);
        chk("R10 mhz at floor", clk_mhz[1], 2);
        apply(1'b1, 16'h2300, 16'h20C3);
        chk("R5 mult0 stays", mult[0], 1);

        // R1 serial framing
        chk("R1 frames seen", (frames > 100) ? 1 : 0, 1);
        if (frame_err != 0)
            $display("FAIL R1 framing: actual lo=%0d hi=%0d expected lo=16 hi=4", bad_lo, bad_hi);
        n_chk++;
        if (frame_err != 0) n_bad++;

        summary();
        $finish;
    end

endmodule